// File: doc/BRIEF.md
# Receive Elasticity Buffer with Framing Insert/Delete

This block carries decoded receive characters from the recovered-clock domain into the local training-clock domain. A 9-bit character is written on the recovered clock whenever its valid strobe is high. It holds 8 data bits and a control flag. The training clock reads one character per cycle. The two clocks are close in frequency but not equal, so the buffer adjusts the stream only at framing-character boundaries. The framing character is the comma with the control flag set and data 8'hBC. When the buffer runs low, it repeats a framing character it has just delivered. When it runs high, it skips a framing character that is waiting at its head. Data characters are never added or removed.

The write pointer crosses into the read domain as Gray code through two flops. The read side estimates the fill from that synchronized copy. A read-side state machine has three states. FILL waits for the fill estimate to reach the nominal level and emits nothing; it moves to RUN once that level is reached. RUN delivers characters. In RUN, a delete skips a framing character and a recenter jumps the read pointer; in both cases the machine stays in RUN. RUN moves to INSERT when it delivers a framing character while the fill is low. INSERT always returns to RUN after emitting one extra framing character. RUN returns to FILL when the buffer is found empty. Reset is active low and sampled on the training clock. The write side uses a copy of the reset that passes through a two-flop synchronizer on the recovered clock.

Top module: `eb_rx_elastic`

## Requirements
- R1: While reset is low and on the first training-clock edge after it is sampled low, the outputs are out_valid=0, out_ctl=1, out_data=8'hBC, ovf_flag=0 and unf_flag=0. They stay defined from then on, well within 16 cycles of release.
- R2: After reset, out_valid stays low until the read-side fill estimate reaches NOMINAL (8). The first valid character is the oldest stored character.
- R3: Every character other than the framing character leaves in write order, with none lost and none repeated, while both error flags are low.
- R4: When a framing character is delivered while the fill estimate is below LO_LVL (4), the next output cycle carries an extra framing character (out_ctl=1, out_data=8'hBC).
- R5: When a framing character is at the head while the fill estimate is above HI_LVL (11), that character is skipped and the following entry is delivered in the same cycle. A character that is not a framing character is never skipped.
- R6: At most one insert or delete is made for each framing character. Isolated framing characters at the input never give three framing characters in a row at the output.
- R7: Only ctl=1 with data 8'hBC counts as framing. Other control characters, such as ctl=1 with data 8'h7C, pass through like data.
- R8: A fill estimate of zero while delivering sets the sticky unf_flag, with out_valid low in that cycle. The block then refills to NOMINAL before delivering again.
- R9: A fill estimate of OVF_LVL (13) or more sets the sticky ovf_flag, with out_valid low in that cycle. The read pointer is placed NOMINAL entries behind the synchronized write pointer, and the characters that follow are consecutive writes.
- R10: A character is stored only when wr_valid is high and the synchronized write reset has been released. Writes offered during reset are discarded.
- R11: The write pointer crosses clock domains as Gray code through two flops, and it changes by at most one bit per recovered-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Training clock, read side |
| rst_n | input | 1 | Active-low reset, sampled on rclk |
| wclk | input | 1 | Recovered clock, write side |
| wr_valid | input | 1 | Write strobe for the character on wr_ctl/wr_data |
| wr_ctl | input | 1 | Control-character flag of the written character |
| wr_data | input | 8 | Data bits of the written character |
| out_valid | output | 1 | A character is delivered this cycle |
| out_ctl | output | 1 | Control flag of the delivered character |
| out_data | output | 8 | Data bits of the delivered character |
| ovf_flag | output | 1 | Sticky overflow indication |
| unf_flag | output | 1 | Sticky underflow indication |

## Verification
A wrong read pointer or a wrong fill estimate shows at the ports within one training-clock cycle. It appears as a data character out of order or missing against the write stream, or as an error flag raised at nominal rates. A missed insert or delete does not corrupt data immediately. Instead it drifts the fill over a few hundred cycles, until the sticky underflow or overflow flag fires or the count of framing characters fails to move in the expected direction. A state machine stuck in FILL or INSERT shows at once as out_valid held low or as a third framing character in a row.

// File: rtl/eb_pkg.sv
package eb_pkg;

    typedef struct packed {
        logic       ctl;
        logic [7:0] data;
    } rx_char_t;

    localparam logic [8:0] FRAME_CHAR = 9'h1BC;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_RUN    = 2'd1,
        ST_INSERT = 2'd2
    } eb_state_t;

    function automatic logic is_frame(input rx_char_t c);
        return (c == rx_char_t'(FRAME_CHAR));
    endfunction

endpackage

// File: rtl/eb_gray_sync.sv
module eb_gray_sync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);

    logic [PW-1:0] stage1;
    logic [PW-1:0] stage2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign bin_out[i] = ^stage2[PW-1:i];
    end

endmodule

// File: rtl/eb_wr_side.sv
module eb_wr_side import eb_pkg::*; #(
    parameter int AW = 4,
    parameter int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  rx_char_t      wr_char,
    output logic          we,
    output logic [AW-1:0] waddr,
    output rx_char_t      wdata,
    output logic [PW-1:0] wptr_gray
);

    logic [1:0]    rst_sync;
    logic          w_rst_n;
    logic [PW-1:0] wptr_bin;
    logic [PW-1:0] wptr_inc;

    always_ff @(posedge wclk) begin
        rst_sync <= {rst_sync[0], rst_n};
    end
    assign w_rst_n = rst_sync[1];

    assign wptr_inc = wptr_bin + PW'(1);
    assign we       = w_rst_n && wr_valid;
    assign waddr    = wptr_bin[AW-1:0];
    assign wdata    = wr_char;

    always_ff @(posedge wclk) begin
        if (!w_rst_n) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
        end else if (wr_valid) begin
            wptr_bin  <= wptr_inc;
            wptr_gray <= wptr_inc ^ (wptr_inc >> 1);
        end
    end

    AST_WPTR_GRAY_STEP: assert property (@(posedge wclk) disable iff (!w_rst_n)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1); // R11

endmodule

// File: rtl/eb_store.sv
module eb_store import eb_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rx_char_t      wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output rx_char_t      rdata_a,
    output rx_char_t      rdata_b
);

    rx_char_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/eb_rd_fsm.sv
module eb_rd_fsm import eb_pkg::*; #(
    parameter int DEPTH   = 16,
    parameter int AW      = $clog2(DEPTH),
    parameter int PW      = AW + 1,
    parameter int NOMINAL = 8,
    parameter int LO_LVL  = 4,
    parameter int HI_LVL  = 11,
    parameter int OVF_LVL = 13
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [PW-1:0] wbin_s,
    input  rx_char_t      head,
    input  rx_char_t      nxt,
    output logic [AW-1:0] raddr_a,
    output logic [AW-1:0] raddr_b,
    output rx_char_t      out_ch,
    output logic          out_vld,
    output logic          ovf_q,
    output logic          unf_q
);

    localparam logic [PW-1:0] NOM_P = PW'(NOMINAL);
    localparam logic [PW-1:0] LO_P  = PW'(LO_LVL);
    localparam logic [PW-1:0] HI_P  = PW'(HI_LVL);
    localparam logic [PW-1:0] OVF_P = PW'(OVF_LVL);

    eb_state_t     st, st_nxt;
    logic [PW-1:0] rptr, rptr_nxt;
    logic [PW-1:0] fill;
    logic          head_frame;
    rx_char_t      ch_nxt;
    logic          vld_nxt, ovf_nxt, unf_nxt;

    assign fill       = wbin_s - rptr;
    assign head_frame = is_frame(head);
    assign raddr_a    = rptr[AW-1:0];
    assign raddr_b    = rptr[AW-1:0] + AW'(1);

    always_comb begin
        st_nxt   = st;
        rptr_nxt = rptr;
        ch_nxt   = rx_char_t'(FRAME_CHAR);
        vld_nxt  = 1'b0;
        ovf_nxt  = ovf_q;
        unf_nxt  = unf_q;
        unique case (st)
            ST_FILL: begin
                if (fill >= NOM_P) begin
                    st_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (fill == '0) begin
                    unf_nxt = 1'b1;
                    st_nxt  = ST_FILL;
                end else if (fill >= OVF_P) begin
                    ovf_nxt  = 1'b1;
                    rptr_nxt = wbin_s - NOM_P;
                end else if (head_frame && (fill > HI_P)) begin
                    ch_nxt   = nxt;
                    vld_nxt  = 1'b1;
                    rptr_nxt = rptr + PW'(2);
                end else begin
                    ch_nxt   = head;
                    vld_nxt  = 1'b1;
                    rptr_nxt = rptr + PW'(1);
                    if (head_frame && (fill < LO_P)) begin
                        st_nxt = ST_INSERT;
                    end
                end
            end
            ST_INSERT: begin
                ch_nxt  = rx_char_t'(FRAME_CHAR);
                vld_nxt = 1'b1;
                st_nxt  = ST_RUN;
            end
            default: begin
                st_nxt = ST_FILL;
            end
        endcase
    end

    // state register
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            st   <= ST_FILL;
            rptr <= '0;
        end else begin
            st   <= st_nxt;
            rptr <= rptr_nxt;
        end
    end

    // output register
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            out_ch  <= rx_char_t'(FRAME_CHAR);
            out_vld <= 1'b0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            out_ch  <= ch_nxt;
            out_vld <= vld_nxt;
            ovf_q   <= ovf_nxt;
            unf_q   <= unf_nxt;
        end
    end

    AST_INSERT_AFTER_FRAME: assert property (@(posedge rclk) disable iff (!rst_n)
        (st == ST_INSERT) |-> (out_vld && (out_ch == rx_char_t'(FRAME_CHAR)))); // R4
    AST_DATA_NOT_SKIPPED: assert property (@(posedge rclk) disable iff (!rst_n)
        (st == ST_RUN && fill != '0 && fill < OVF_P && !head_frame)
            |=> (rptr == $past(rptr) + PW'(1))); // R5
    AST_FILL_SILENT: assert property (@(posedge rclk) disable iff (!rst_n)
        (st == ST_FILL) |=> !out_vld); // R2
    AST_UNF_STICKY: assert property (@(posedge rclk) disable iff (!rst_n)
        unf_q |=> unf_q); // R8
    AST_OVF_STICKY: assert property (@(posedge rclk) disable iff (!rst_n)
        ovf_q |=> ovf_q); // R9

endmodule

// File: rtl/eb_rx_elastic.sv
module eb_rx_elastic import eb_pkg::*; #(
    parameter int DEPTH   = 16,
    parameter int NOMINAL = 8,
    parameter int LO_LVL  = 4,
    parameter int HI_LVL  = 11,
    parameter int OVF_LVL = 13
) (
    input  logic       rclk,
    input  logic       rst_n,
    input  logic       wclk,
    input  logic       wr_valid,
    input  logic       wr_ctl,
    input  logic [7:0] wr_data,
    output logic       out_valid,
    output logic       out_ctl,
    output logic [7:0] out_data,
    output logic       ovf_flag,
    output logic       unf_flag
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    rx_char_t      wr_char, wdata, head, nxt, out_ch;
    logic          we;
    logic [AW-1:0] waddr, raddr_a, raddr_b;
    logic [PW-1:0] wptr_gray, wbin_s;

    assign wr_char = '{ctl: wr_ctl, data: wr_data};

    eb_wr_side #(.AW(AW), .PW(PW)) u_wr (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_char   (wr_char),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .wptr_gray (wptr_gray)
    );

    eb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .wclk    (wclk),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (raddr_a),
        .raddr_b (raddr_b),
        .rdata_a (head),
        .rdata_b (nxt)
    );

    eb_gray_sync #(.PW(PW)) u_sync (
        .clk     (rclk),
        .rst_n   (rst_n),
        .gray_in (wptr_gray),
        .bin_out (wbin_s)
    );

    eb_rd_fsm #(
        .DEPTH(DEPTH), .AW(AW), .PW(PW), .NOMINAL(NOMINAL),
        .LO_LVL(LO_LVL), .HI_LVL(HI_LVL), .OVF_LVL(OVF_LVL)
    ) u_rd (
        .rclk    (rclk),
        .rst_n   (rst_n),
        .wbin_s  (wbin_s),
        .head    (head),
        .nxt     (nxt),
        .raddr_a (raddr_a),
        .raddr_b (raddr_b),
        .out_ch  (out_ch),
        .out_vld (out_valid),
        .ovf_q   (ovf_flag),
        .unf_q   (unf_flag)
    );

    assign out_ctl  = out_ch.ctl;
    assign out_data = out_ch.data;

endmodule

// File: tb/sim_eb_rx_elastic.sv
`timescale 1ps/1ps
module sim_eb_rx_elastic;

    logic       rclk = 1'b0;
    logic       wclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_ctl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       out_valid, out_ctl, ovf_flag, unf_flag;
    logic [7:0] out_data;

    int checks = 0;
    int failures = 0;
    int whalf = 2500;
    int wmode = 0;       // 0 idle, 1 framed random, 2 sequence, 3 junk
    int wr_count = 0;
    int in_commas = 0;
    int out_commas = 0;
    int comma_run = 0;
    int k7c_seen = 0;
    int slot = 0;
    bit mon_en = 1'b0;
    bit mon_sb = 1'b0;
    logic [7:0] seq = 8'h00;
    logic [8:0] wc;
    logic [8:0] oc;
    logic [8:0] expq[$];

    always #2500 rclk = ~rclk;
    initial begin
        #700;
        forever #(whalf) wclk = ~wclk;
    end

    eb_rx_elastic u0 (
        .rclk(rclk), .rst_n(rst_n), .wclk(wclk), .wr_valid(wr_valid),
        .wr_ctl(wr_ctl), .wr_data(wr_data), .out_valid(out_valid),
        .out_ctl(out_ctl), .out_data(out_data), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] gen_char(input int s);
        logic [8:0] c;
        if (s == 5) return 9'h1BC;
        c = {1'b0, 8'($urandom)};
        if ($urandom % 8 == 0) c = 9'h17C;
        return c;
    endfunction

    // writer, drives on the falling edge of the recovered clock
    always @(negedge wclk) begin
        wr_valid = 1'b0;
        case (wmode)
            1: begin
                wc = gen_char(slot);
                slot = (slot == 5) ? 0 : slot + 1;
                wr_valid = 1'b1; wr_ctl = wc[8]; wr_data = wc[7:0];
                if (wc == 9'h1BC) in_commas++;
                else expq.push_back(wc);
                wr_count++;
            end
            2: begin
                wr_valid = 1'b1; wr_ctl = 1'b0; wr_data = seq;
                seq = seq + 8'd1;
                wr_count++;
            end
            3: begin
                wr_valid = 1'b1; wr_ctl = 1'b0; wr_data = 8'hEE;
            end
            default: ;
        endcase
    end

    // monitor, samples on the falling edge of the training clock
    always @(negedge rclk) begin
        if (mon_en && out_valid) begin
            oc = {out_ctl, out_data};
            if (oc == 9'h1BC) begin
                out_commas++;
                comma_run++;
                chk(comma_run < 3, "R6", "framing run length", comma_run, 2);
            end else begin
                comma_run = 0;
                if (oc == 9'h17C) k7c_seen++;
                if (mon_sb) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R3 R10 R11", "unexpected char", int'(oc), -1);
                    end else begin
                        chk(oc == expq[0], "R3 R5 R7 R11", "char order",
                            int'(oc), int'(expq[0]));
                        void'(expq.pop_front());
                    end
                end
            end
        end
    end

    task automatic do_reset();
        mon_en = 1'b0;
        wmode = 3;
        rst_n = 1'b0;
        repeat (4) @(posedge rclk);
        @(negedge rclk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk({out_ctl, out_data} == 9'h1BC, "R1", "idle char in reset",
            int'({out_ctl, out_data}), 'h1BC);
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R1", "flags in reset",
            int'({ovf_flag, unf_flag}), 0);
        expq.delete();
        comma_run = 0;
        rst_n = 1'b1;
        @(posedge wclk);
        wmode = 0;
        repeat (3) @(posedge wclk);
    endtask

    task automatic write_chars(input int n);
        int base;
        base = wr_count;
        wait (wr_count >= base + n);
    endtask

    initial begin
        int ic0, oc0, base, prev;
        bit seen;
        void'($urandom(32'h5EED_0401));

        // reset state and idle after release
        do_reset();
        for (int i = 0; i < 16; i++) begin
            @(negedge rclk);
            chk(out_valid == 1'b0, "R2", "no output while empty", out_valid, 0);
        end

        // nominal rate, prefill and first character
        mon_sb = 1'b1;
        mon_en = 1'b1;
        slot = 0;
        base = wr_count;
        wmode = 1;
        @(negedge rclk);
        while (!out_valid) @(negedge rclk);
        chk(wr_count - base >= 8, "R2", "writes before first output",
            wr_count - base, 8);
        write_chars(600);
        chk(k7c_seen > 0, "R7", "other control chars delivered", k7c_seen, 1);

        // slow writer: inserts expected
        whalf = 2580;
        ic0 = in_commas; oc0 = out_commas;
        write_chars(3000);
        chk((out_commas - oc0) > (in_commas - ic0), "R4", "framing chars added",
            out_commas - oc0, in_commas - ic0 + 1);
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R4", "no error on slow writer",
            int'({ovf_flag, unf_flag}), 0);

        // fast writer: deletes expected
        whalf = 2440;
        ic0 = in_commas; oc0 = out_commas;
        write_chars(3000);
        chk((in_commas - ic0) > (out_commas - oc0) + 4, "R5", "framing chars dropped",
            out_commas - oc0, in_commas - ic0 - 5);
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R3", "no error on fast writer",
            int'({ovf_flag, unf_flag}), 0);

        // underflow
        whalf = 2500;
        wmode = 0;
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge rclk);
            if (unf_flag) seen = 1'b1;
        end
        chk(seen, "R8", "underflow flag", seen, 1);
        chk(out_valid == 1'b0, "R8", "out_valid at underflow", out_valid, 0);
        chk(expq.size() == 0, "R3", "all data delivered before underflow",
            expq.size(), 0);
        comma_run = 0;
        base = wr_count;
        wmode = 1;
        @(negedge rclk);
        while (!out_valid) @(negedge rclk);
        chk(wr_count - base >= 8, "R8", "refill before resume", wr_count - base, 8);
        write_chars(200);
        chk(unf_flag == 1'b1, "R8", "underflow flag sticky", unf_flag, 1);
        wmode = 0;
        repeat (40) @(negedge rclk);

        // overflow
        do_reset();
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R1", "flags cleared by reset",
            int'({ovf_flag, unf_flag}), 0);
        mon_sb = 1'b0;
        mon_en = 1'b1;
        whalf = 2270;
        wmode = 2;
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge rclk);
            if (ovf_flag) seen = 1'b1;
        end
        chk(seen, "R9", "overflow flag", seen, 1);
        chk(out_valid == 1'b0, "R9", "out_valid at overflow", out_valid, 0);
        chk(unf_flag == 1'b0, "R9", "no underflow with overflow", unf_flag, 0);
        prev = -1;
        for (int n = 0; n < 10; ) begin
            @(negedge rclk);
            if (out_valid) begin
                if (prev >= 0)
                    chk(out_data == 8'(prev + 1), "R9 R10", "consecutive after recenter",
                        out_data, (prev + 1) % 256);
                prev = out_data;
                n++;
            end
        end
        wmode = 0;
        chk(ovf_flag == 1'b1, "R9", "overflow flag sticky", ovf_flag, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge rclk);
        failures++;
        $display("FAIL watchdog all requirements act=%0d exp=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule